// File: doc/BRIEF.md
# Scalar Float Compare Flag Unit

This block takes two IEEE-754 single-precision operands, orders them, and hands back a six-bit condition word in processor-status form. The ordering is one of four outcomes: unordered (some operand is a NaN), first operand greater, first operand less, or equal. The outcome is packed into a fixed pattern on the zero, parity and carry flags; the overflow, sign and auxiliary flags are always cleared. The flag word is registered and appears one clock after a valid strobe, together with a one-cycle flag-write enable and two exception indications (invalid and denormal).

A mode input chooses the invalid-operation policy. In quiet mode only a signaling NaN raises invalid; in signaling mode any NaN does. Denormal operands compare by their true value and raise the denormal indication. If a raised exception has its mask bit clear, the flag word is not updated and the write enable stays low. A suppress input silences both exception outputs and forces the update through.

Control is a two-state machine. `ST_IDLE` presents no result. Transition *accept* (valid high) moves from `ST_IDLE` to `ST_REPORT`; transition *stream* (valid high) keeps `ST_REPORT`; transition *drain* (valid low) returns `ST_REPORT` to `ST_IDLE`; transition *wait* (valid low) keeps `ST_IDLE`. Results are shown only in `ST_REPORT`.

Top module: `fcmp_flag_unit`

## Requirements
- R1: A compare accepted at a rising edge (in_valid high) is presented on flag_wr, exc_invalid and exc_denormal during the following clock cycle only; with in_valid low at an edge those three outputs are low in the next cycle.
- R2: If either operand is a NaN the written flag word has ZF=1, PF=1, CF=1. Flag bit positions: flags_q[5]=ZF, [4]=PF, [3]=CF, [2]=OF, [1]=SF, [0]=AF.
- R3: For ordered operands the written ZF,PF,CF are 0,0,0 when opnd_a > opnd_b, 0,0,1 when opnd_a < opnd_b and 1,0,0 when equal; +0 equals -0, infinities order beyond all finite values, and denormals compare by true value.
- R4: Every written flag word has OF, SF and AF equal to 0.
- R5: An operand is a NaN when bits [30:23] are all ones and bits [22:0] are nonzero; it is a signaling NaN when bit 22 is also 0. All-ones exponent with zero mantissa is an infinity, not a NaN.
- R6: With sig_mode=0 (quiet), exc_invalid is raised only when at least one operand is a signaling NaN.
- R7: With sig_mode=1 (signaling), exc_invalid is raised when either operand is any NaN.
- R8: exc_denormal is raised when either operand has exponent 0 and a nonzero mantissa.
- R9: When invalid is raised with inv_mask=0, or denormal is raised with den_mask=0, flag_wr stays low and flags_q keeps its previous value.
- R10: With suppress_all=1, exc_invalid and exc_denormal stay low and flag_wr is high for that compare.
- R11: After reset, flags_q is 0 and flag_wr, exc_invalid and exc_denormal are low.
- R12: flags_q changes only in a cycle where flag_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opnd_a | input | 32 | First single-precision operand |
| opnd_b | input | 32 | Second single-precision operand |
| sig_mode | input | 1 | 0 quiet compare, 1 signaling compare |
| inv_mask | input | 1 | 1 masks the invalid exception |
| den_mask | input | 1 | 1 masks the denormal exception |
| suppress_all | input | 1 | 1 silences all exceptions and forces the flag write |
| flags_q | output | 6 | Registered flag word {ZF,PF,CF,OF,SF,AF} |
| flag_wr | output | 1 | Flag word was written this cycle |
| exc_invalid | output | 1 | Invalid-operation indication |
| exc_denormal | output | 1 | Denormal-operand indication |

## Verification
Every result of this block is due exactly one clock after the edge that accepted the strobe: the flag word, the write enable and both exception bits all change on that edge and hold for one cycle, while the flag word then holds until the next permitted write. The bench drives operands on the falling edge, updates a behavioural model on the rising edge from the same inputs the design sees, and compares all four outputs at the next falling edge, so each comparison lands in the one cycle where the result is due. Directed pairs cover signed zeros, infinities, denormals, both NaN kinds in both modes, and every mask and suppress combination, followed by a long stretch of mixed random and special operands with idle gaps and back-to-back strobes.

// File: rtl/fcmp_pkg.sv
`timescale 1ns/1ps
package fcmp_pkg;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } st_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_den;
        logic is_zero;
    } opcls_t;

    localparam int FLAG_W = 6;

endpackage

// File: rtl/fcmp_classify.sv
`timescale 1ns/1ps
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W-1:0] mag,
    output opcls_t                 cls
);
    localparam logic [EXP_W-1:0] EXP_ONES = '1;
    localparam int               QBIT     = MAN_W - 1;

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;
    logic             man_nz;

    assign expo   = mag[EXP_W+MAN_W-1:MAN_W];
    assign mant   = mag[MAN_W-1:0];
    assign man_nz = |mant;

    always_comb begin
        cls.is_nan  = (expo == EXP_ONES) && man_nz;
        cls.is_snan = (expo == EXP_ONES) && man_nz && !mant[QBIT];
        cls.is_den  = (expo == '0) && man_nz;
        cls.is_zero = (expo == '0) && !man_nz;
    end

endmodule

// File: rtl/fcmp_order.sv
`timescale 1ns/1ps
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] val_a,
    input  logic [WORD_W-1:0] val_b,
    input  logic              any_nan,
    input  logic              both_zero,
    output rel_e              rel
);
    logic [WORD_W-1:0] key_a;
    logic [WORD_W-1:0] key_b;

    // Map sign-magnitude to a key whose unsigned order is the numeric order.
    function automatic logic [WORD_W-1:0] order_key(input logic [WORD_W-1:0] v);
        if (v[WORD_W-1]) order_key = ~v;
        else             order_key = {1'b1, v[WORD_W-2:0]};
    endfunction

    assign key_a = order_key(val_a);
    assign key_b = order_key(val_b);

    always_comb begin
        if (any_nan)            rel = REL_UN;
        else if (both_zero)     rel = REL_EQ;
        else if (key_a > key_b) rel = REL_GT;
        else if (key_a < key_b) rel = REL_LT;
        else                    rel = REL_EQ;
    end

endmodule

// File: rtl/fcmp_policy.sv
`timescale 1ns/1ps
module fcmp_policy (
    input  logic [1:0] nan,
    input  logic [1:0] snan,
    input  logic [1:0] den,
    input  logic       sig_mode,
    input  logic       inv_mask,
    input  logic       den_mask,
    input  logic       suppress_all,
    output logic       raise_inv,
    output logic       raise_den,
    output logic       allow_wr
);
    logic inv_hit;
    logic den_hit;

    always_comb begin
        inv_hit   = sig_mode ? (|nan) : (|snan);
        den_hit   = |den;
        raise_inv = inv_hit && !suppress_all;
        raise_den = den_hit && !suppress_all;
        allow_wr  = !((raise_inv && !inv_mask) || (raise_den && !den_mask));
    end

endmodule

// File: rtl/fcmp_flag_unit.sv
`timescale 1ns/1ps
module fcmp_flag_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [EXP_W+MAN_W:0]     opnd_a,
    input  logic [EXP_W+MAN_W:0]     opnd_b,
    input  logic                     sig_mode,
    input  logic                     inv_mask,
    input  logic                     den_mask,
    input  logic                     suppress_all,
    output logic [FLAG_W-1:0]        flags_q,
    output logic                     flag_wr,
    output logic                     exc_invalid,
    output logic                     exc_denormal
);
    localparam int WORD_W = EXP_W + MAN_W + 1;
    localparam int NOPND  = 2;

    logic [WORD_W-1:0] opnd [NOPND];
    opcls_t            cls  [NOPND];
    logic [NOPND-1:0]  nan_v, snan_v, den_v, zero_v;

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    for (genvar g = 0; g < NOPND; g++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .mag (opnd[g][WORD_W-2:0]),
            .cls (cls[g])
        );
        assign nan_v[g]  = cls[g].is_nan;
        assign snan_v[g] = cls[g].is_snan;
        assign den_v[g]  = cls[g].is_den;
        assign zero_v[g] = cls[g].is_zero;
    end

    rel_e rel;
    logic raise_inv, raise_den, allow_wr;

    fcmp_order #(.WORD_W(WORD_W)) u_order (
        .val_a     (opnd_a),
        .val_b     (opnd_b),
        .any_nan   (|nan_v),
        .both_zero (&zero_v),
        .rel       (rel)
    );

    fcmp_policy u_policy (
        .nan          (nan_v),
        .snan         (snan_v),
        .den          (den_v),
        .sig_mode     (sig_mode),
        .inv_mask     (inv_mask),
        .den_mask     (den_mask),
        .suppress_all (suppress_all),
        .raise_inv    (raise_inv),
        .raise_den    (raise_den),
        .allow_wr     (allow_wr)
    );

    // ZF,PF,CF pattern for each outcome; OF,SF,AF always zero.
    logic [2:0] zpc;
    always_comb begin
        unique case (rel)
            REL_UN:  zpc = 3'b111;
            REL_GT:  zpc = 3'b000;
            REL_LT:  zpc = 3'b001;
            REL_EQ:  zpc = 3'b100;
            default: zpc = 3'b111;
        endcase
    end

    st_e state, state_nx;

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = in_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_nx = in_valid ? ST_REPORT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q      <= '0;
            flag_wr      <= 1'b0;
            exc_invalid  <= 1'b0;
            exc_denormal <= 1'b0;
        end else if (in_valid) begin
            flag_wr      <= allow_wr;
            exc_invalid  <= raise_inv;
            exc_denormal <= raise_den;
            if (allow_wr) flags_q <= {zpc, 3'b000};
        end else begin
            flag_wr      <= 1'b0;
            exc_invalid  <= 1'b0;
            exc_denormal <= 1'b0;
        end
    end

    // Outputs only show a result one cycle after an accepted strobe.
    assert_report_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr || exc_invalid || exc_denormal) |-> $past(in_valid));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !(flag_wr || exc_invalid || exc_denormal));

    assert_upper_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |-> (flags_q[2:0] == 3'b000));

    assert_legal_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |-> (flags_q[5:3] inside {3'b111, 3'b000, 3'b001, 3'b100}));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |-> $stable(flags_q));

    assert_suppress_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && suppress_all) |-> (flag_wr && !exc_invalid && !exc_denormal));

    assert_unmasked_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_invalid && !$past(inv_mask)) |-> !flag_wr);

    assert_nan_unordered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && $past(in_valid && (|nan_v))) |-> (flags_q[5:3] == 3'b111));

endmodule

// File: tb/sim_fcmp_flag_unit.sv
`timescale 1ns/1ps
module sim_fcmp_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        sig_mode = 1'b0, inv_mask = 1'b1, den_mask = 1'b1, suppress_all = 1'b0;
    logic [5:0]  flags_q;
    logic        flag_wr, exc_invalid, exc_denormal;

    always #4 clk = ~clk;

    fcmp_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sig_mode(sig_mode),
        .inv_mask(inv_mask), .den_mask(den_mask), .suppress_all(suppress_all),
        .flags_q(flags_q), .flag_wr(flag_wr),
        .exc_invalid(exc_invalid), .exc_denormal(exc_denormal)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string stim_tag = "R11";
    string exp_tag  = "R11";
    logic [5:0] m_flags = '0;
    logic       m_wr = 1'b0, m_inv = 1'b0, m_den = 1'b0;

    function automatic bit is_nan(bit [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic bit is_snan(bit [31:0] x);
        return is_nan(x) && !x[22];
    endfunction
    function automatic bit is_den(bit [31:0] x);
        return (x[30:23] == 0) && (x[22:0] != 0);
    endfunction
    function automatic real to_real(bit [31:0] x);
        real v;
        int  e;
        e = int'(x[30:23]);
        if (e == 255)     v = 1.0e300;
        else if (e == 0)  v = real'(x[22:0]) * (2.0 ** (-149));
        else              v = real'(int'(x[22:0]) + 8388608) * (2.0 ** (e - 150));
        return x[31] ? -v : v;
    endfunction

    // Behavioural reference, updated at the same edge as the design.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flags <= '0; m_wr <= 0; m_inv <= 0; m_den <= 0; exp_tag <= "R11";
        end else if (in_valid) begin
            bit  inv, den, wr;
            real ra, rb;
            logic [2:0] z;
            inv = sig_mode ? (is_nan(opnd_a) || is_nan(opnd_b))
                           : (is_snan(opnd_a) || is_snan(opnd_b));
            den = is_den(opnd_a) || is_den(opnd_b);
            if (suppress_all) begin inv = 0; den = 0; end
            wr = !((inv && !inv_mask) || (den && !den_mask));
            ra = to_real(opnd_a); rb = to_real(opnd_b);
            if (is_nan(opnd_a) || is_nan(opnd_b)) z = 3'b111;
            else if (ra > rb)                    z = 3'b000;
            else if (ra < rb)                    z = 3'b001;
            else                                 z = 3'b100;
            m_wr <= wr; m_inv <= inv; m_den <= den;
            if (wr) m_flags <= {z, 3'b000};
            exp_tag <= stim_tag;
        end else begin
            m_wr <= 0; m_inv <= 0; m_den <= 0;
            exp_tag <= "R1,R12";
        end
    end

    always @(negedge clk) begin
        n_cmp++;
        if ({flags_q, flag_wr, exc_invalid, exc_denormal} !== {m_flags, m_wr, m_inv, m_den}) begin
            n_bad++;
            $display("FAIL %s: flags=%b wr=%b inv=%b den=%b expected flags=%b wr=%b inv=%b den=%b",
                     exp_tag, flags_q, flag_wr, exc_invalid, exc_denormal,
                     m_flags, m_wr, m_inv, m_den);
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic m,
                         input logic im, input logic dm, input logic s, input string tag);
        @(negedge clk);
        opnd_a = a; opnd_b = b; sig_mode = m; inv_mask = im; den_mask = dm;
        suppress_all = s; stim_tag = tag; in_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    localparam logic [31:0] ONE = 32'h3F800000, TWO = 32'h40000000, THREE = 32'h40400000;
    localparam logic [31:0] QN = 32'h7FC00000, SN = 32'h7F800001;
    localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000, FMAX = 32'h7F7FFFFF;

    logic [31:0] pool [12];

    initial begin
        pool = '{32'h0, 32'h80000000, ONE, 32'hBF800000, PINF, NINF, QN, SN,
                 32'h00000001, 32'h807FFFFF, FMAX, 32'hFFFFFFFF};
        repeat (3) @(negedge clk);          // reset state checked here (R11)
        rst_n = 1'b1;
        idle(2);
        apply(THREE, TWO, 0, 1, 1, 0, "R3 greater");
        apply(ONE, TWO, 0, 1, 1, 0, "R3 less");
        apply(ONE, ONE, 0, 1, 1, 0, "R3 equal");
        apply(32'h0, 32'h80000000, 0, 1, 1, 0, "R3 signed zeros");
        apply(NINF, FMAX, 0, 1, 1, 0, "R3 -inf less");
        apply(PINF, FMAX, 0, 1, 1, 0, "R3,R5 +inf greater");
        apply(PINF, PINF, 0, 1, 1, 0, "R5 inf equal");
        apply(32'hC0000000, 32'hBF800000, 0, 1, 1, 0, "R3,R4 negatives");
        idle(2);
        apply(QN, ONE, 0, 0, 1, 0, "R2,R6 qnan quiet");
        apply(SN, ONE, 0, 1, 1, 0, "R2,R5,R6 snan quiet masked");
        apply(ONE, QN, 1, 1, 1, 0, "R7 qnan signaling masked");
        apply(32'hFFFFFFFF, ONE, 1, 0, 1, 0, "R7,R9 qnan signaling unmasked");
        apply(ONE, SN, 0, 0, 1, 0, "R9 snan quiet unmasked");
        idle(1);
        apply(32'h00000001, 32'h0, 0, 1, 1, 0, "R8 denormal masked");
        apply(32'h0, 32'h00000001, 0, 1, 0, 0, "R8,R9 denormal unmasked");
        apply(32'h00000002, 32'h00000001, 0, 1, 1, 0, "R3,R8 denormal order");
        apply(32'h80000000, 32'h00000001, 0, 1, 1, 0, "R3 -0 vs denormal");
        apply(SN, 32'h00000001, 0, 0, 0, 1, "R10 suppress");
        apply(ONE, TWO, 0, 1, 1, 0, "R12 write after suppress");
        idle(3);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            a = ($urandom % 3 == 0) ? $urandom : pool[$urandom % 12];
            b = ($urandom % 3 == 0) ? $urandom : pool[$urandom % 12];
            if ($urandom % 5 == 0) b = a;
            apply(a, b, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 6 == 0),
                  "R2,R3,R6,R7,R8,R9,R10 mixed");
            if ($urandom % 4 == 0) idle(1 + $urandom % 2);
        end
        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule